// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Error Flags

This block receives asynchronous serial frames on a single input line and presents them to software through a small register window. Each frame has a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The line is sampled sixteen times per bit. The sample rate is set by a divisor input. A completed byte is placed in a data register and a buffer-full flag is raised. Parity, framing and overrun conditions each raise their own sticky status bit.

Software reads the byte at offset 0, and that read clears the buffer-full flag. The status word is at offset 1. Error flags are removed through a separate write-one-to-clear register at offset 2, so writing back the status value just read clears exactly the errors that were seen. Reception is switched on with a start strobe at offset 3 and off with a stop strobe at offset 4. The running state can be read at offset 5. Stopping and restarting the channel realigns the receiver after a framing error caused by a misplaced start bit.

Top module: `uart_rx_chan`

## Requirements
- R1: After reset, the data register, the status word and the enable bit (offset 5, bit 0) all read 0.
- R2: A frame with a start bit of 0, eight data bits LSB first and a stop bit of 1 is received. Each bit lasts 16 sample ticks, and one tick is `cfg_div` clocks long (0 behaves as 1). The byte appears at offset 0 and status bit 5 (buffer-full) is set.
- R3: `cfg_par` selects the parity mode: 0 none, 1 even, 2 odd, 3 none. With parity on, a parity bit follows the data. If the parity bit does not match the mode, status bit 1 is set.
- R4: A stop bit sampled as 0 sets status bit 2 (framing). The byte is still stored and buffer-full is set.
- R5: A read of offset 0 clears buffer-full, and the next frame is then accepted normally.
- R6: A frame that completes while buffer-full is set raises status bit 0 (overrun). The new byte is discarded and the older byte stays at offset 0.
- R7: A write to offset 2 clears each of status bits 0, 1 and 2 whose matching write bit is 1. Write bits of 0 leave the flags unchanged. Writing back a value read from status clears exactly those flags.
- R8: Writing 1 to bit 0 of offset 3 sets the enable bit, and writing 1 to bit 0 of offset 4 clears it. Writing 0 to either offset has no effect, and both offsets always read 0.
- R9: While disabled, the receiver stays idle and no frame is received. The data register and the flags keep their values.
- R10: A low pulse on the line that is high again at the mid-point of the start bit is treated as noise, and no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of offset 0 has a side effect) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rx_pin | input | 1 | Asynchronous serial input, idles high |
| cfg_div | input | 16 | Clocks per sample tick |
| cfg_par | input | 2 | Parity mode |

## Verification
All 256 byte values are received with the parity mode rotating between none, even and odd. This separates bit-order and parity errors from value-specific faults. A second divisor setting confirms that the tick length comes from `cfg_div`. Deliberately corrupted frames are then sent: a wrong parity bit, a stop bit of 0, two frames back to back without a read, and a short low glitch. Each one must raise only its own flag, or none at all for the glitch. Clear-mask patterns and start/stop strobe sequences, including writes of 0 and reception while disabled, check that the flags and the stored byte are kept or cleared exactly as the requirements say.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OVS       = 16;
    localparam int OVS_W     = $clog2(OVS);
    localparam int DATA_BITS = 8;

    localparam logic [2:0] ADR_DATA  = 3'd0;
    localparam logic [2:0] ADR_STAT  = 3'd1;
    localparam logic [2:0] ADR_CLR   = 3'd2;
    localparam logic [2:0] ADR_START = 3'd3;
    localparam logic [2:0] ADR_STOP  = 3'd4;
    localparam logic [2:0] ADR_EN    = 3'd5;

    localparam int ST_OVR = 0;
    localparam int ST_PER = 1;
    localparam int ST_FER = 2;
    localparam int ST_BFF = 5;

    localparam logic [7:0] ERR_MASK  = 8'h07;
    localparam logic [7:0] STAT_MASK = 8'h27;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 par_err;
        logic                 frm_err;
    } rx_frame_t;

    function automatic logic par_enabled(par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    function automatic logic par_expect(logic [DATA_BITS-1:0] d, par_mode_e m);
        return (m == PAR_ODD) ? ~(^d) : (^d);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= 2'b11;
        else     stage_q <= {stage_q[0], din};
    end

    assign dout = stage_q[1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    assign limit = (div == '0) ? '0 : div - 1'b1;
    assign tick  = run && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      tick,
    input  logic      rx_s,
    input  logic [1:0] cfg_par,
    output logic      done,
    output rx_frame_t frame
);
    localparam logic [OVS_W-1:0] HALF = OVS_W'(OVS/2 - 1);
    localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);
    localparam int BIT_W = $clog2(DATA_BITS);

    par_mode_e            mode;
    rx_state_e            state_q;
    logic [OVS_W-1:0]     cnt_q;
    logic [BIT_W-1:0]     bit_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic                 par_bit_q;
    logic                 at_end;

    assign mode   = par_mode_e'(cfg_par);
    assign at_end = tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            bit_q     <= '0;
            shreg_q   <= '0;
            par_bit_q <= 1'b0;
            done      <= 1'b0;
            frame     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (tick && !rx_s) begin
                        state_q <= RX_START;
                        cnt_q   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt_q == HALF) begin
                            cnt_q   <= '0;
                            bit_q   <= '0;
                            state_q <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (at_end) begin
                        cnt_q   <= '0;
                        shreg_q <= {rx_s, shreg_q[DATA_BITS-1:1]};
                        if (bit_q == BIT_W'(DATA_BITS - 1))
                            state_q <= par_enabled(mode) ? RX_PAR : RX_STOP;
                        else
                            bit_q <= bit_q + 1'b1;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (at_end) begin
                        cnt_q     <= '0;
                        par_bit_q <= rx_s;
                        state_q   <= RX_STOP;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (at_end) begin
                        cnt_q         <= '0;
                        done          <= 1'b1;
                        frame.data    <= shreg_q;
                        frame.frm_err <= !rx_s;
                        frame.par_err <= par_enabled(mode) &&
                                         (par_bit_q != par_expect(shreg_q, mode));
                        state_q       <= RX_IDLE;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !run |=> (state_q == RX_IDLE) && !done)                         // R9
        else $error("receiver active while disabled");

    AST_NOISE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_START && tick && cnt_q == HALF && rx_s && run) |=> state_q == RX_IDLE) // R10
        else $error("false start not rejected");

endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       done,
    input  rx_frame_t  frame,
    output logic       run
);
    logic [7:0] data_q;
    logic [7:0] stat_q;
    logic       rd_data, wr_clr, wr_start, wr_stop;

    assign rd_data  = bus_rd && (bus_addr == ADR_DATA);
    assign wr_clr   = bus_wr && (bus_addr == ADR_CLR);
    assign wr_start = bus_wr && (bus_addr == ADR_START) && bus_wdata[0];
    assign wr_stop  = bus_wr && (bus_addr == ADR_STOP)  && bus_wdata[0];

    always_comb begin
        unique case (bus_addr)
            ADR_DATA: bus_rdata = data_q;
            ADR_STAT: bus_rdata = stat_q & STAT_MASK;
            ADR_EN:   bus_rdata = {7'b0, run};
            default:  bus_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            data_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_start) run <= 1'b1;
            if (wr_stop)  run <= 1'b0;
            if (wr_clr)   stat_q <= stat_q & ~(bus_wdata & ERR_MASK);
            if (rd_data)  stat_q[ST_BFF] <= 1'b0;
            if (done) begin
                if (stat_q[ST_BFF]) begin
                    stat_q[ST_OVR] <= 1'b1;
                end else begin
                    data_q         <= frame.data;
                    stat_q[ST_BFF] <= 1'b1;
                    stat_q[ST_PER] <= stat_q[ST_PER] | frame.par_err;
                    stat_q[ST_FER] <= stat_q[ST_FER] | frame.frm_err;
                end
            end
        end
    end

    AST_READ_CLEARS_BFF: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !done) |=> !stat_q[ST_BFF])                        // R5
        else $error("buffer-full survived data read");

    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        (done && stat_q[ST_BFF]) |=> stat_q[ST_OVR] && $stable(data_q)) // R6
        else $error("overrun handling wrong");

    AST_START_SETS_EN: assert property (@(posedge clk) disable iff (rst)
        (wr_start && !wr_stop) |=> run)                                // R8
        else $error("start strobe ignored");

    AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        wr_stop |=> !run)                                              // R8
        else $error("stop strobe ignored");

    AST_NO_RX_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !run |-> !done)                                                // R9
        else $error("frame completed while disabled");

endmodule

// File: rtl/uart_rx_chan.sv
module uart_rx_chan
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             rx_pin,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       cfg_par
);
    logic      rx_s;
    logic      run;
    logic      tick;
    logic      done;
    rx_frame_t frame;

    uart_rx_sync u_sync (
        .clk (clk),
        .rst (rst),
        .din (rx_pin),
        .dout(rx_s)
    );

    uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk (clk),
        .rst (rst),
        .run (run),
        .div (cfg_div),
        .tick(tick)
    );

    uart_rx_frame u_frame (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .rx_s   (rx_s),
        .cfg_par(cfg_par),
        .done   (done),
        .frame  (frame)
    );

    uart_rx_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .done     (done),
        .frame    (frame),
        .run      (run)
    );
endmodule

// File: tb/sim_uart_rx_chan.sv
`timescale 1ns/1ps
module sim_uart_rx_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        rx_pin = 1'b1;
    logic [15:0] cfg_div = 16'd1;
    logic [1:0]  cfg_par = 2'd0;

    int n_chk = 0, n_fail = 0;
    int div_now = 1;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_rx_chan u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_pin(rx_pin), .cfg_div(cfg_div), .cfg_par(cfg_par)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic hold_bit(input logic v);
        rx_pin = v;
        repeat (16 * div_now) @(negedge clk);
    endtask

    // mode: 0 none, 1 even, 2 odd; bad_par flips parity; stop_v is stop bit level
    task automatic send(input logic [7:0] b, input int mode, input bit bad_par, input logic stop_v);
        logic p;
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        if (mode == 1 || mode == 2) begin
            p = (mode == 2) ? ~(^b) : (^b);
            hold_bit(p ^ bad_par);
        end
        hold_bit(stop_v);
        rx_pin = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(3'd0, v); check("R1 data", v, 8'h00);
        rd(3'd1, v); check("R1 status", v, 8'h00);
        rd(3'd5, v); check("R1 enable", v, 8'h00);

        // R8 triggers read 0, start sets enable
        wr(3'd3, 8'h01);
        rd(3'd5, v); check("R8 start", v, 8'h01);
        rd(3'd3, v); check("R8 start reads 0", v, 8'h00);
        rd(3'd4, v); check("R8 stop reads 0", v, 8'h00);
        wr(3'd4, 8'h00);
        rd(3'd5, v); check("R8 stop write 0 no effect", v, 8'h01);

        // R2/R3/R5 sweep over all bytes with rotating parity mode
        for (int b = 0; b < 256; b++) begin
            cfg_par = 2'(b % 3);
            send(8'(b), b % 3, 1'b0, 1'b1);
            rd(3'd1, v); check("R2 status bff", v, 8'h20);
            rd(3'd0, v); check("R2 data", v, 8'(b));
            rd(3'd1, v); check("R5 bff cleared", v, 8'h00);
        end

        // R2 divisor change
        cfg_div = 16'd3; div_now = 3; cfg_par = 2'd1;
        send(8'hA5, 1, 1'b0, 1'b1);
        rd(3'd0, v); check("R2 div3 data", v, 8'hA5);
        cfg_par = 2'd3;
        send(8'h3C, 0, 1'b0, 1'b1);
        rd(3'd0, v); check("R3 mode3 as none", v, 8'h3C);
        rd(3'd1, v); check("R3 mode3 no error", v, 8'h00);
        cfg_div = 16'd1; div_now = 1;

        // R3 parity error, odd mode; R7 zero-mask and writeback clear
        cfg_par = 2'd2;
        send(8'h5A, 2, 1'b1, 1'b1);
        rd(3'd1, v); check("R3 parity error", v, 8'h22);
        wr(3'd2, 8'h00);
        rd(3'd1, v); check("R7 zero mask no effect", v, 8'h22);
        rd(3'd0, v); check("R3 data kept", v, 8'h5A);
        rd(3'd1, v);
        wr(3'd2, v);
        rd(3'd1, v); check("R7 writeback clears", v, 8'h00);

        // R6 overrun
        cfg_par = 2'd0;
        send(8'h11, 0, 1'b0, 1'b1);
        send(8'h22, 0, 1'b0, 1'b1);
        rd(3'd1, v); check("R6 overrun flag", v, 8'h21);
        rd(3'd0, v); check("R6 older byte kept", v, 8'h11);
        wr(3'd2, 8'h02);
        rd(3'd1, v); check("R7 other bit mask keeps ovr", v, 8'h01);
        wr(3'd2, 8'h01);
        rd(3'd1, v); check("R7 clear ovr", v, 8'h00);

        // R4 framing error, then stop/start resync
        send(8'hC3, 0, 1'b0, 1'b0);
        wr(3'd4, 8'h01);
        rd(3'd1, v); check("R4 framing flag", v, 8'h24);
        rd(3'd0, v); check("R4 data stored", v, 8'hC3);
        repeat (40) @(negedge clk);
        wr(3'd3, 8'h01);
        wr(3'd2, 8'h04);
        send(8'h7E, 0, 1'b0, 1'b1);
        rd(3'd0, v); check("R4 resync data", v, 8'h7E);
        rd(3'd1, v); check("R4 resync status", v, 8'h00);

        // R9 stopped channel keeps state and ignores line
        send(8'h99, 0, 1'b0, 1'b1);
        wr(3'd4, 8'h01);
        rd(3'd5, v); check("R8 stop clears enable", v, 8'h00);
        rd(3'd1, v); check("R9 flags kept", v, 8'h20);
        send(8'h44, 0, 1'b0, 1'b1);
        rd(3'd1, v); check("R9 no overrun when off", v, 8'h20);
        rd(3'd0, v); check("R9 data kept", v, 8'h99);
        wr(3'd3, 8'h00);
        rd(3'd5, v); check("R8 start write 0 no effect", v, 8'h00);
        send(8'h55, 0, 1'b0, 1'b1);
        rd(3'd1, v); check("R9 nothing received off", v, 8'h00);
        wr(3'd3, 8'h01);

        // R10 false start
        @(negedge clk);
        rx_pin = 1'b0;
        repeat (4) @(negedge clk);
        rx_pin = 1'b1;
        repeat (300) @(negedge clk);
        rd(3'd1, v); check("R10 glitch ignored", v, 8'h00);
        send(8'h0F, 0, 1'b0, 1'b1);
        rd(3'd0, v); check("R10 receiver still works", v, 8'h0F);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule